// File: doc/BRIEF.md
# Accumulator ALU with Flag Register

This block is the arithmetic and logic core of a small accumulator-based 8-bit controller. Each cycle it takes an operation code, the accumulator value, a second operand (from memory or an immediate) and a bit index. It produces an 8-bit result at once, with no register on the path. The caller decides where that result is written.

The block also holds three status flags: carry (C), half carry (DC) and zero (Z). The current carry feeds the carry-using operations. When the enable input is high, the next clock edge writes the new flag values. Only the flags that the operation class may touch are written, and the block exposes this set as a per-flag write mask.

Subtraction uses the inverted-borrow convention. After a subtract, C is 1 when no borrow occurred. Subtract-with-borrow removes the complement of C.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) gives result = (acc + opnd) mod 256, and the C flag written is the carry out of bit 7.
- R2: Op 1 (add with carry) gives result = (acc + opnd + C) mod 256, and C is written to 1 exactly when that 9-bit sum exceeds 255.
- R3: Op 2 (subtract) gives result = (acc - opnd) mod 256. C is written to 0 when opnd > acc (a borrow) and to 1 otherwise.
- R4: Op 3 (subtract with borrow) gives result = (acc - opnd - (1 - C)) mod 256. C is written to 0 on borrow and to 1 otherwise.
- R5: For ops 0 and 1, DC is the carry out of bit 3. For ops 2 and 3, DC is 1 when the low nibble produces no borrow and 0 when it does. Ops 0 to 3 write C, DC and Z, so the mask is 3'b111.
- R6: Every op that writes Z sets it to 1 exactly when its 8-bit result is 0x00.
- R7: Op 4 (AND), op 5 (OR) and op 6 (XOR) give the bitwise function of acc and opnd. They write only Z (mask 3'b001) and leave C and DC unchanged.
- R8: Op 7 (swap) outputs opnd with its upper and lower nibbles exchanged. It writes no flag (mask 3'b000).
- R9: Op 8 (rotate right) gives {C, opnd[7:1]} and writes C from opnd[0]. Op 9 (rotate left) gives {opnd[6:0], C} and writes C from opnd[7]. Both write only C (mask 3'b100).
- R10: Op 10 gives 0x00. Op 11 sets bit bit_sel of opnd, and op 12 clears bit bit_sel of opnd. None of these three writes a flag (mask 3'b000).
- R11: All flags reset to 0. A flag changes only on a rising clock edge with en high and its mask bit set. Mask bit order is [2]=C, [1]=DC, [0]=Z.
- R12: Ops 13 to 15 pass opnd to the result unchanged and write no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| en | input | 1 | Commit the masked flags at the next edge |
| op | input | 4 | Operation code |
| acc | input | 8 | Accumulator operand |
| opnd | input | 8 | Memory or immediate operand |
| bit_sel | input | 3 | Bit index for single-bit set and clear |
| result | output | 8 | Combinational result |
| wmask | output | 3 | Flags this op may write: [2]=C, [1]=DC, [0]=Z |
| c_flag | output | 1 | Registered carry flag |
| dc_flag | output | 1 | Registered half-carry flag |
| z_flag | output | 1 | Registered zero flag |

## Verification
The arithmetic ops are driven with operand pairs chosen to separate the cases. Some pairs carry out of bit 7 only, and some carry out of bit 3 only. Others borrow in the high byte or in the low nibble only, and some give a zero result. Together these separate the C, DC and Z paths and confirm the inverted-borrow sense.

Add-with-carry and subtract-with-borrow each run once with C at 0 and once with C at 1, which shows that the carry input is used. Logic, swap, rotate and clear ops run right after other ops have set C and DC, so an unwanted flag write shows up as a changed flag. A cycle with en low and a cycle with an unused code confirm that the flags are held.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [3:0]           op,
  input  logic [W-1:0]         acc,
  input  logic [W-1:0]         opnd,
  input  logic [$clog2(W)-1:0] bit_sel,
  output logic [W-1:0]         result,
  output logic [2:0]           wmask,
  output logic                 c_flag,
  output logic                 dc_flag,
  output logic                 z_flag
);
  localparam int H = W / 2;
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3,
                         OP_AND = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_SWP = 4'd7,
                         OP_RRC = 4'd8, OP_RLC = 4'd9, OP_CLR = 4'd10, OP_BST = 4'd11,
                         OP_BCL = 4'd12;

  logic         is_sub, cin;
  logic [W-1:0] b;
  logic [W:0]   sum;
  logic [H:0]   hsum;
  logic         nc, ndc, nz;

  assign is_sub = op[1];
  assign b      = is_sub ? ~opnd : opnd;
  assign cin    = op[0] ? c_flag : is_sub;
  assign sum    = {1'b0, acc} + {1'b0, b} + {{W{1'b0}}, cin};
  assign hsum   = {1'b0, acc[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};

  always_comb begin
    result = opnd;
    wmask  = 3'b000;
    nc     = c_flag;
    ndc    = dc_flag;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        result = sum[W-1:0];
        nc     = sum[W];
        ndc    = hsum[H];
        wmask  = 3'b111;
      end
      OP_AND: begin result = acc & opnd; wmask = 3'b001; end
      OP_OR:  begin result = acc | opnd; wmask = 3'b001; end
      OP_XOR: begin result = acc ^ opnd; wmask = 3'b001; end
      OP_SWP: result = {opnd[H-1:0], opnd[W-1:H]};
      OP_RRC: begin result = {c_flag, opnd[W-1:1]}; nc = opnd[0];   wmask = 3'b100; end
      OP_RLC: begin result = {opnd[W-2:0], c_flag}; nc = opnd[W-1]; wmask = 3'b100; end
      OP_CLR: result = '0;
      OP_BST: result = opnd | (W'(1) << bit_sel);
      OP_BCL: result = opnd & ~(W'(1) << bit_sel);
      default: result = opnd;
    endcase
  end

  assign nz = (result == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_flag  <= 1'b0;
      dc_flag <= 1'b0;
      z_flag  <= 1'b0;
    end else if (en) begin
      if (wmask[2]) c_flag  <= nc;
      if (wmask[1]) dc_flag <= ndc;
      if (wmask[0]) z_flag  <= nz;
    end
  end

  p_hold_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable({c_flag, dc_flag, z_flag}));

  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_ADD) |=> {c_flag, $past(result)} == ({1'b0, $past(acc)} + {1'b0, $past(opnd)}));

  p_sub_noborrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_SUB) |=> c_flag == ($past(acc) >= $past(opnd)));

  p_sbc_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_SBC) |=> $past(result) == W'($past(acc) - $past(opnd) - {{(W-1){1'b0}}, ~$past(c_flag)}));

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wmask[0]) |=> z_flag == ($past(result) == '0));

  p_logic_keeps_c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> $stable({c_flag, dc_flag}));

  p_rrc_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_RRC) |=> c_flag == $past(opnd[0]) && $stable({dc_flag, z_flag}));

  p_noflag_ops_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_SWP || op >= OP_CLR)) |=> $stable({c_flag, dc_flag, z_flag}));
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] acc = 8'h00, opnd = 8'h00;
  logic [2:0] bit_sel = 3'd0;
  logic [7:0] result;
  logic [2:0] wmask;
  logic       c_flag, dc_flag, z_flag;
  logic [7:0] r_s;
  logic [2:0] m_s;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  acc_alu u_dut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .acc(acc), .opnd(opnd),
    .bit_sel(bit_sel), .result(result), .wmask(wmask), .c_flag(c_flag),
    .dc_flag(dc_flag), .z_flag(z_flag));

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                      input logic [2:0] bs, input logic e);
    @(negedge clk);
    op = o; acc = a; opnd = b; bit_sel = bs; en = e;
    #1;
    r_s = result; m_s = wmask;
    @(posedge clk); #1;
    en = 1'b0;
  endtask

  task automatic expect_all(input string tag, input logic [7:0] r, input logic [2:0] m,
                            input logic [2:0] f);
    chk({tag, " result"}, {1'b0, r_s}, {1'b0, r});
    chk({tag, " mask"}, {6'd0, m_s}, {6'd0, m});
    chk({tag, " flags CDZ"}, {6'd0, c_flag, dc_flag, z_flag}, {6'd0, f});
  endtask

  task automatic t_reset;
    chk("R11 reset flags", {6'd0, c_flag, dc_flag, z_flag}, 9'd0);
  endtask

  task automatic t_add;
    step(0, 8'h3A, 8'h28, 0, 1); expect_all("R1 R5 add nibble carry", 8'h62, 3'b111, 3'b010);
    step(0, 8'hF0, 8'h20, 0, 1); expect_all("R1 R5 add high carry", 8'h10, 3'b111, 3'b100);
  endtask

  task automatic t_adc;
    step(0, 8'hFF, 8'h01, 0, 1); expect_all("R6 add to zero", 8'h00, 3'b111, 3'b111);
    step(1, 8'h10, 8'h20, 0, 1); expect_all("R2 adc with C=1", 8'h31, 3'b111, 3'b000);
    step(1, 8'hFF, 8'h00, 0, 1); expect_all("R2 adc with C=0", 8'hFF, 3'b111, 3'b000);
    step(0, 8'hFF, 8'h01, 0, 1);
    step(1, 8'hFF, 8'h00, 0, 1); expect_all("R2 adc wrap", 8'h00, 3'b111, 3'b111);
  endtask

  task automatic t_sub;
    step(2, 8'h50, 8'h20, 0, 1); expect_all("R3 sub no borrow", 8'h30, 3'b111, 3'b110);
    step(2, 8'h20, 8'h50, 0, 1); expect_all("R3 sub borrow", 8'hD0, 3'b111, 3'b010);
    step(2, 8'h10, 8'h01, 0, 1); expect_all("R5 sub nibble borrow", 8'h0F, 3'b111, 3'b100);
    step(2, 8'h33, 8'h33, 0, 1); expect_all("R6 sub equal", 8'h00, 3'b111, 3'b111);
  endtask

  task automatic t_sbc;
    step(3, 8'h33, 8'h03, 0, 1); expect_all("R4 sbc with C=1", 8'h30, 3'b111, 3'b110);
    step(2, 8'h00, 8'h01, 0, 1);
    step(3, 8'h33, 8'h03, 0, 1); expect_all("R4 sbc with C=0", 8'h2F, 3'b111, 3'b100);
  endtask

  task automatic t_logic;
    step(0, 8'hFF, 8'h01, 0, 1);
    step(4, 8'hF0, 8'h0F, 0, 1); expect_all("R7 and", 8'h00, 3'b001, 3'b111);
    step(5, 8'hF0, 8'h0F, 0, 1); expect_all("R7 or", 8'hFF, 3'b001, 3'b110);
    step(6, 8'h5A, 8'h0F, 0, 1); expect_all("R7 xor", 8'h55, 3'b001, 3'b110);
  endtask

  task automatic t_swap_rot;
    step(7, 8'h00, 8'h3C, 0, 1); expect_all("R8 swap", 8'hC3, 3'b000, 3'b110);
    step(8, 8'h00, 8'h02, 0, 1); expect_all("R9 rrc", 8'h81, 3'b100, 3'b010);
    step(9, 8'h00, 8'h80, 0, 1); expect_all("R9 rlc", 8'h00, 3'b100, 3'b110);
  endtask

  task automatic t_bits;
    step(10, 8'h12, 8'h34, 0, 1); expect_all("R10 clr no Z", 8'h00, 3'b000, 3'b110);
    step(11, 8'h00, 8'h00, 5, 1); expect_all("R10 bit set", 8'h20, 3'b000, 3'b110);
    step(12, 8'h00, 8'hFF, 0, 1); expect_all("R10 bit clear", 8'hFE, 3'b000, 3'b110);
  endtask

  task automatic t_hold;
    step(2, 8'h00, 8'h01, 0, 0); expect_all("R11 en low holds", 8'hFF, 3'b111, 3'b110);
    step(13, 8'h00, 8'h00, 0, 1); expect_all("R12 unused op", 8'h00, 3'b000, 3'b110);
    step(15, 8'h11, 8'hA5, 0, 1); expect_all("R12 unused op pass", 8'hA5, 3'b000, 3'b110);
  endtask

  initial begin
    #10 rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_add;
    t_adc;
    t_sub;
    t_sbc;
    t_logic;
    t_swap_rot;
    t_bits;
    t_hold;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #20000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule